// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller sequences a small microcontroller core through four power modes: Normal, Idle, Suspend and Shutdown. Software requests a mode by writing bits into three small control registers through a write port: a power register, an oscillator register and a regulator register. The controller decides whether the request is legal and moves its state machine. The gating outputs for the core clock, the peripheral clocks, the internal power nets and the pin-retention latch are decoded from the registered state alone.

Each low-power mode has its own entry rule and its own wake source. Idle needs one write and ends on any pending interrupt. Suspend is allowed only while the system clock runs from the internal high-frequency oscillator, and only bus activity ends it. Shutdown must be armed in the regulator register before a stop write triggers it, and only the reset pin or power-on reset ends it. Every exit from Shutdown passes through a one-cycle Reset state that restores all control bits to their defaults before Normal.

States: ST_NORMAL, ST_IDLE, ST_SUSP, ST_SHUT, ST_RESET. Transitions: power-on reset to ST_RESET; any state with pin reset to ST_RESET; ST_RESET to ST_NORMAL; ST_NORMAL to ST_SHUT on an armed stop write; ST_NORMAL to ST_IDLE on an idle write; ST_NORMAL to ST_SUSP on a suspend write while the oscillator is the clock source; ST_IDLE to ST_NORMAL on a pending interrupt; ST_SUSP to ST_NORMAL on bus activity.

Top module: `pwr_mode_seq`

## Requirements
- R1: Power-on reset (`por_n` low) or `pin_rst` high for a clock edge puts the block in Reset (`mode`=4) for exactly one cycle, then Normal (`mode`=0). Leaving Reset clears `idle_bit`, `susp_bit`, `stop_bit`, `arm_bit` and `susp_err` and sets `reg5v_en` to 1.
- R2: `mode` encodes Normal=0, Idle=1, Suspend=2, Shutdown=3, Reset=4. {core_clk_en, periph_clk_en, pwr_net_en, pin_hold} is 1110 in Normal, 0110 in Idle, 0010 in Suspend, 0001 in Shutdown and 0010 in Reset.
- R3: A write to select 0 with data bit 0 set enters Idle at that edge, and `idle_bit` reads 1. A high `irq_pend` returns the block to Normal at the next edge, and `idle_bit` reads 0 afterwards.
- R4: A write to select 1 with data bit 0 set enters Suspend only when `clk_src_hfo` is 1, and `susp_bit` reads 1. In Suspend `irq_pend` has no effect. A high `bus_act` returns the block to Normal and clears `susp_bit`.
- R5: A suspend write while `clk_src_hfo` is 0 leaves the block in Normal and sets `susp_err`. The flag stays set until the next reset.
- R6: A write to select 2 sets `arm_bit` from data bit 0 and `reg5v_en` from data bit 1. A later write to select 0 with data bit 1 set enters Shutdown only if `arm_bit` is 1. Without the arm bit the stop write is ignored.
- R7: In Shutdown, `irq_pend`, `bus_act` and writes have no effect, `reg5v_en` keeps its value and `pin_hold` is 1. Only a reset ends the mode.
- R8: Writes are accepted only in Normal. A power-register write with both the stop and idle bits set enters Shutdown when armed.
- R9: The gating outputs change only when the registered state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_rst | input | 1 | Synchronous external reset pin, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 power, 1 oscillator, 2 regulator |
| wr_data | input | 8 | Write data |
| irq_pend | input | 1 | An enabled interrupt is pending |
| bus_act | input | 1 | USB bus activity detected |
| clk_src_hfo | input | 1 | System clock is sourced from the high-frequency oscillator |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| pwr_net_en | output | 1 | Internal power-net enable |
| pin_hold | output | 1 | Pin retention latch enable |
| reg5v_en | output | 1 | 5V regulator enable |
| susp_err | output | 1 | Sticky flag for an illegal suspend request |
| idle_bit | output | 1 | Idle request bit readback |
| susp_bit | output | 1 | Suspend request bit readback |
| stop_bit | output | 1 | Stop request bit readback |
| arm_bit | output | 1 | Shutdown arm bit readback |
| mode | output | 3 | Current state code |

## Verification
The bench sweeps the oscillator-source input against the suspend request. A design that skipped the clock-source check would enter Suspend with the wrong clock, and one that failed to latch the error would lose the flag. It sweeps the arm bit and the regulator bit against the stop write. A design that treated stop as a single step would shut down unarmed, and one that disturbed the regulator bit would change its output in Shutdown. It drives interrupts during Suspend and Shutdown, and writes during Idle. It also varies how long Idle lasts before its interrupt, so that a wrong wake source, a write accepted outside Normal, or a request bit left set after wake shows at the ports. Shutdown exits are checked to pass through Reset and land in Normal with all bits at their defaults.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_IDLE   = 3'd1,
        ST_SUSP   = 3'd2,
        ST_SHUT   = 3'd3,
        ST_RESET  = 3'd4
    } pm_state_t;

    localparam int SEL_W     = 2;
    localparam int DATA_W    = 8;
    localparam logic [SEL_W-1:0] SEL_PWR = 2'd0;
    localparam logic [SEL_W-1:0] SEL_OSC = 2'd1;
    localparam logic [SEL_W-1:0] SEL_REG = 2'd2;
    localparam int BIT_IDLE  = 0;
    localparam int BIT_STOP  = 1;
    localparam int BIT_SUSP  = 0;
    localparam int BIT_ARM   = 0;
    localparam int BIT_REG5V = 1;

endpackage

// File: rtl/pms_ctl_regs.sv
module pms_ctl_regs
    import pms_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          clk_src_hfo,
    input  logic          pin_rst,
    input  pm_state_t     state_q,
    input  pm_state_t     state_nxt,
    output logic          req_idle,
    output logic          req_stop,
    output logic          req_susp,
    output logic          arm_q,
    output logic          reg5v_q,
    output logic          err_q,
    output logic          idle_q,
    output logic          susp_q,
    output logic          stop_q
);

    logic wr_ok;

    assign wr_ok    = wr_en && (state_q == ST_NORMAL);
    assign req_idle = wr_ok && (wr_sel == SW'(SEL_PWR)) && wr_data[BIT_IDLE];
    assign req_stop = wr_ok && (wr_sel == SW'(SEL_PWR)) && wr_data[BIT_STOP];
    assign req_susp = wr_ok && (wr_sel == SW'(SEL_OSC)) && wr_data[BIT_SUSP];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            arm_q   <= 1'b0;
            reg5v_q <= 1'b1;
            err_q   <= 1'b0;
            idle_q  <= 1'b0;
            susp_q  <= 1'b0;
            stop_q  <= 1'b0;
        end else if (state_nxt == ST_RESET) begin
            arm_q   <= 1'b0;
            reg5v_q <= 1'b1;
            err_q   <= 1'b0;
            idle_q  <= 1'b0;
            susp_q  <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            if (wr_ok && (wr_sel == SW'(SEL_REG))) begin
                arm_q   <= wr_data[BIT_ARM];
                reg5v_q <= wr_data[BIT_REG5V];
            end
            if (req_susp && !clk_src_hfo)
                err_q <= 1'b1;
            idle_q <= (state_nxt == ST_IDLE);
            susp_q <= (state_nxt == ST_SUSP);
            stop_q <= (state_nxt == ST_SHUT);
        end
    end

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!por_n)
        (err_q && !pin_rst) |=> err_q);

    assert_reg5v_held_R7: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_SHUT && !pin_rst) |=> $stable(reg5v_q));

endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
    import pms_pkg::*;
(
    input  logic      clk,
    input  logic      por_n,
    input  logic      pin_rst,
    input  logic      req_idle,
    input  logic      req_stop,
    input  logic      req_susp,
    input  logic      arm_q,
    input  logic      clk_src_hfo,
    input  logic      irq_pend,
    input  logic      bus_act,
    output pm_state_t state_q,
    output pm_state_t state_nxt
);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_RESET;
        else        state_q <= state_nxt;
    end

    always_comb begin
        state_nxt = state_q;
        if (pin_rst) begin
            state_nxt = ST_RESET;
        end else begin
            unique case (state_q)
                ST_NORMAL: begin
                    if (req_stop && arm_q)          state_nxt = ST_SHUT;
                    else if (req_idle)              state_nxt = ST_IDLE;
                    else if (req_susp && clk_src_hfo) state_nxt = ST_SUSP;
                end
                ST_IDLE:  if (irq_pend) state_nxt = ST_NORMAL;
                ST_SUSP:  if (bus_act)  state_nxt = ST_NORMAL;
                ST_SHUT:  state_nxt = ST_SHUT;
                ST_RESET: state_nxt = ST_NORMAL;
                default:  state_nxt = ST_RESET;
            endcase
        end
    end

    assert_reset_once_R1: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_RESET && !pin_rst) |=> state_q == ST_NORMAL);

    assert_susp_needs_hfo_R4: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_NORMAL && !clk_src_hfo) |=> state_q != ST_SUSP);

    assert_susp_irq_ignored_R4: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_SUSP && !bus_act && !pin_rst) |=> state_q == ST_SUSP);

    assert_shut_needs_arm_R6: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_NORMAL && !arm_q) |=> state_q != ST_SHUT);

    assert_shut_exit_pin_R7: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_SHUT && !pin_rst) |=> state_q == ST_SHUT);

endmodule

// File: rtl/pms_gate_dec.sv
module pms_gate_dec
    import pms_pkg::*;
(
    input  pm_state_t state_q,
    output logic      core_clk_en,
    output logic      periph_clk_en,
    output logic      pwr_net_en,
    output logic      pin_hold
);

    always_comb begin
        core_clk_en   = 1'b0;
        periph_clk_en = 1'b0;
        pwr_net_en    = 1'b1;
        pin_hold      = 1'b0;
        unique case (state_q)
            ST_NORMAL: begin
                core_clk_en   = 1'b1;
                periph_clk_en = 1'b1;
            end
            ST_IDLE:  periph_clk_en = 1'b1;
            ST_SUSP:  ;
            ST_SHUT: begin
                pwr_net_en = 1'b0;
                pin_hold   = 1'b1;
            end
            ST_RESET: ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          pin_rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          irq_pend,
    input  logic          bus_act,
    input  logic          clk_src_hfo,
    output logic          core_clk_en,
    output logic          periph_clk_en,
    output logic          pwr_net_en,
    output logic          pin_hold,
    output logic          reg5v_en,
    output logic          susp_err,
    output logic          idle_bit,
    output logic          susp_bit,
    output logic          stop_bit,
    output logic          arm_bit,
    output logic [2:0]    mode
);

    pm_state_t state_q;
    pm_state_t state_nxt;
    logic      req_idle;
    logic      req_stop;
    logic      req_susp;

    pms_ctl_regs #(.SW(SW), .DW(DW)) u_regs (
        .clk         (clk),
        .por_n       (por_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .clk_src_hfo (clk_src_hfo),
        .pin_rst     (pin_rst),
        .state_q     (state_q),
        .state_nxt   (state_nxt),
        .req_idle    (req_idle),
        .req_stop    (req_stop),
        .req_susp    (req_susp),
        .arm_q       (arm_bit),
        .reg5v_q     (reg5v_en),
        .err_q       (susp_err),
        .idle_q      (idle_bit),
        .susp_q      (susp_bit),
        .stop_q      (stop_bit)
    );

    pms_fsm u_fsm (
        .clk         (clk),
        .por_n       (por_n),
        .pin_rst     (pin_rst),
        .req_idle    (req_idle),
        .req_stop    (req_stop),
        .req_susp    (req_susp),
        .arm_q       (arm_bit),
        .clk_src_hfo (clk_src_hfo),
        .irq_pend    (irq_pend),
        .bus_act     (bus_act),
        .state_q     (state_q),
        .state_nxt   (state_nxt)
    );

    pms_gate_dec u_gate (
        .state_q       (state_q),
        .core_clk_en   (core_clk_en),
        .periph_clk_en (periph_clk_en),
        .pwr_net_en    (pwr_net_en),
        .pin_hold      (pin_hold)
    );

    assign mode = state_q;

    assert_gate_stable_R9: assert property (@(posedge clk) disable iff (!por_n)
        $stable(mode) |-> $stable({core_clk_en, periph_clk_en, pwr_net_en, pin_hold}));

    assert_idle_wake_R3: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 3'd1 && irq_pend && !pin_rst) |=> (mode == 3'd0 && !idle_bit));

endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb_top;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       pin_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       irq_pend = 1'b0;
    logic       bus_act = 1'b0;
    logic       clk_src_hfo = 1'b0;
    logic       core_clk_en, periph_clk_en, pwr_net_en, pin_hold;
    logic       reg5v_en, susp_err, idle_bit, susp_bit, stop_bit, arm_bit;
    logic [2:0] mode;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    pwr_mode_seq dut_i (
        .clk(clk), .por_n(por_n), .pin_rst(pin_rst), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .irq_pend(irq_pend),
        .bus_act(bus_act), .clk_src_hfo(clk_src_hfo),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
        .pwr_net_en(pwr_net_en), .pin_hold(pin_hold), .reg5v_en(reg5v_en),
        .susp_err(susp_err), .idle_bit(idle_bit), .susp_bit(susp_bit),
        .stop_bit(stop_bit), .arm_bit(arm_bit), .mode(mode)
    );

    function automatic logic [3:0] gates_for(input logic [2:0] m);
        case (m)
            3'd0:    return 4'b1110;
            3'd1:    return 4'b0110;
            3'd2:    return 4'b0010;
            3'd3:    return 4'b0001;
            default: return 4'b0010;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_mode(input string tag, input logic [2:0] m);
        chk({tag, " mode"}, int'(mode), int'(m));
        chk({tag, " R2 gates"},
            int'({core_clk_en, periph_clk_en, pwr_net_en, pin_hold}),
            int'(gates_for(m)));
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_pin_reset();
        pin_rst = 1'b1;
        @(negedge clk);
        pin_rst = 1'b0;
        chk_mode("R1 pin reset state", 3'd4);
        chk("R1 arm cleared", int'(arm_bit), 0);
        chk("R1 err cleared", int'(susp_err), 0);
        chk("R1 reg5v default", int'(reg5v_en), 1);
        chk("R1 stop cleared", int'(stop_bit), 0);
        @(negedge clk);
        chk_mode("R1 normal after reset", 3'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: power-on reset
        repeat (2) @(negedge clk);
        chk_mode("R1 por held", 3'd4);
        por_n = 1'b1;
        chk_mode("R1 por released", 3'd4);
        @(negedge clk);
        chk_mode("R1 por to normal", 3'd0);
        chk("R1 idle bit", int'(idle_bit), 0);
        chk("R1 susp bit", int'(susp_bit), 0);
        chk("R1 reg5v", int'(reg5v_en), 1);

        // R3 / R9: idle with varied wait before interrupt
        for (int d = 0; d < 4; d++) begin
            wr(2'd0, 8'h01);
            chk_mode("R3 idle entry", 3'd1);
            chk("R3 idle bit set", int'(idle_bit), 1);
            for (int k = 0; k < d; k++) begin
                @(negedge clk);
                chk_mode("R9 idle stable", 3'd1);
            end
            irq_pend = 1'b1;
            @(negedge clk);
            irq_pend = 1'b0;
            chk_mode("R3 idle wake", 3'd0);
            chk("R3 idle bit cleared", int'(idle_bit), 0);
        end

        // R4 / R5: sweep clock source against suspend request
        for (int h = 0; h < 2; h++) begin
            do_pin_reset();
            clk_src_hfo = h[0];
            wr(2'd1, 8'h01);
            chk_mode("R4 R5 suspend request", h ? 3'd2 : 3'd0);
            chk("R5 err flag", int'(susp_err), h ? 0 : 1);
            chk("R4 susp bit", int'(susp_bit), h);
            if (h == 1) begin
                irq_pend = 1'b1;
                repeat (3) @(negedge clk);
                irq_pend = 1'b0;
                chk_mode("R4 irq ignored in suspend", 3'd2);
                bus_act = 1'b1;
                @(negedge clk);
                bus_act = 1'b0;
                chk_mode("R4 bus wake", 3'd0);
                chk("R4 susp bit cleared", int'(susp_bit), 0);
            end else begin
                wr(2'd0, 8'h01);
                irq_pend = 1'b1;
                @(negedge clk);
                irq_pend = 1'b0;
                chk("R5 err sticky", int'(susp_err), 1);
            end
        end
        clk_src_hfo = 1'b0;

        // R6 / R7: sweep arm and regulator bits against stop write
        for (int a = 0; a < 2; a++) begin
            for (int r = 0; r < 2; r++) begin
                do_pin_reset();
                wr(2'd2, {6'd0, r[0], a[0]});
                chk("R6 arm readback", int'(arm_bit), a);
                chk("R6 reg5v readback", int'(reg5v_en), r);
                wr(2'd0, 8'h02);
                chk_mode("R6 stop write", a ? 3'd3 : 3'd0);
                chk("R6 stop bit", int'(stop_bit), a);
                if (a == 1) begin
                    irq_pend = 1'b1; bus_act = 1'b1;
                    wr(2'd2, 8'h00);
                    @(negedge clk);
                    irq_pend = 1'b0; bus_act = 1'b0;
                    chk_mode("R7 shutdown holds", 3'd3);
                    chk("R7 reg5v unchanged", int'(reg5v_en), r);
                    chk("R7 arm unchanged by write", int'(arm_bit), 1);
                    do_pin_reset();
                end
            end
        end

        // R8: stop beats idle when both set and armed
        wr(2'd2, 8'h03);
        wr(2'd0, 8'h03);
        chk_mode("R8 stop over idle", 3'd3);
        do_pin_reset();

        // R8: writes during idle are ignored
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h01);
        irq_pend = 1'b1;
        @(negedge clk);
        irq_pend = 1'b0;
        chk_mode("R8 wake after ignored write", 3'd0);
        chk("R8 arm not set in idle", int'(arm_bit), 0);
        wr(2'd0, 8'h02);
        chk_mode("R8 unarmed stop stays normal", 3'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule